// File: doc/BRIEF.md
# HDLC Serial Transmitter with Abort Lockout

This block turns a byte stream from a transmit FIFO into the serial bit stream of one HDLC channel. One bit leaves on each clock cycle in which the bit-enable input is high. In packet mode it wraps each frame in flags, inserts zeros into the frame contents and adds a 16-bit frame check sequence. In transparent mode it passes bytes through unchanged. When there is nothing to send, it repeats an idle byte, either 7Eh or FFh, chosen by an input.

If the FIFO runs dry inside a packet, or the upstream error input goes high while a packet or a transparent stream is active, the channel sends an abort of eight ones. After that it repeats the idle byte and ignores the FIFO until a channel reset. A status output stays high for as long as the channel is held in this state.

Top module: `hdlcTx`

## Requirements
- R1: After reset or channel reset, txBit is 1, aborted is 0 and fifoPop is 0 until the first enabled bit.
- R2: With nothing to send, the idle byte is repeated, least-significant bit first: 7Eh when idleFF is 0, FFh when idleFF is 1. The idle byte is never zero-stuffed.
- R3: In packet mode (pktMode=1), a frame goes out as follows: an opening flag 7Eh, the data bytes LSB first, then the one's complement of a CRC-16, then a closing flag 7Eh. The CRC uses generator x^16+x^12+x^5+1, is processed bit-reflected with a preset of FFFFh, and is sent low byte first. The byte marked by fifoLast ends the frame. Frames sent back to back each get their own opening and closing flag.
- R4: Inside packet data and the CRC, a zero is inserted after every five consecutive ones. This includes five ones at the end of the CRC that come just before the closing flag. Flags, abort and idle bytes are not stuffed.
- R5: If the FIFO is empty when a data byte is due inside a packet (no fifoLast seen yet), an abort byte FFh is sent in that byte slot. The channel then locks.
- R6: If upErr is high during a packet (after the opening flag is chosen and before the closing flag is chosen), the next byte slot carries the abort. The channel then locks.
- R7: In packet mode, upErr between frames has no effect.
- R8: In transparent mode (pktMode=0), FIFO bytes are sent unchanged with no stuffing and no flags, and fifoLast is ignored. When the FIFO is empty, the idle byte is sent and no abort occurs.
- R9: In transparent mode, upErr at any time causes an abort in the next byte slot, followed by the lock.
- R10: While locked, aborted is 1, fifoPop stays 0 and only idle bytes are sent, until chanReset clears the lock.
- R11: While bitEn is 0, txBit holds its value and no state advances.
- R12: fifoPop pulses once for each data byte taken, and only when fifoValid and bitEn are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chanReset | input | 1 | Synchronous channel reset; clears the abort lock |
| bitEn | input | 1 | Send one bit this cycle |
| pktMode | input | 1 | 1 for packet mode, 0 for transparent mode |
| idleFF | input | 1 | Idle byte select: 0 gives 7Eh, 1 gives FFh |
| upErr | input | 1 | Upstream error indication |
| fifoValid | input | 1 | FIFO head holds a byte |
| fifoData | input | 8 | FIFO head byte |
| fifoLast | input | 1 | FIFO head byte ends a packet |
| fifoPop | output | 1 | Takes the FIFO head byte |
| txBit | output | 1 | Serial line output |
| aborted | output | 1 | Channel is locked after an abort |

## Verification
Packet frames are sent with contents full of ones, so that stuffing occurs inside data, inside the CRC and before the closing flag. These are set against frames of zeros, which shows that stuffing happens only where five ones occur. Back-to-back frames check that each frame gets its own flags. Transparent runs of FFh show that stuffing is off in that mode. A FIFO that runs dry inside a frame is compared with a transparent FIFO that runs dry, which separates an underflow abort from plain idle fill. An error pulse between frames is compared with one inside a frame, to show that only an active frame is armed. Queueing data while the channel is locked, and pausing the bit enable mid-frame, show that the lock and the pause each freeze the FIFO and the line.

// File: rtl/hdlcTxPkg.sv
package hdlcTxPkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W  = 16;

  typedef enum logic [2:0] {
    SRC_FILL, SRC_FLAG, SRC_ABORT, SRC_DATA, SRC_FCSLO, SRC_FCSHI
  } byteSrc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BODY, ST_FCS0, ST_FCS1, ST_END, ST_LOCK
  } txState_e;

  // strobes from control to datapath, valid in a byte-slot cycle
  typedef struct packed {
    byteSrc_e src;
    logic     stuffOn;
    logic     crcClear;
    logic     crcAdd;
  } txStrobe_t;
endpackage

// File: rtl/hdlcTxCtrl.sv
module hdlcTxCtrl
  import hdlcTxPkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chanReset,
  input  logic      pktMode,
  input  logic      upErr,
  input  logic      fifoValid,
  input  logic      fifoLast,
  input  logic      needByte,
  output txStrobe_t strb,
  output logic      fifoPop,
  output logic      aborted
);
  txState_e st, stNext;
  logic errLatch, errArm, abortGo;

  // errors count only inside an active frame, or anytime in transparent mode
  assign errArm = (st != ST_LOCK) && (!pktMode || st != ST_IDLE);

  always_comb begin
    strb     = '{src: SRC_FILL, stuffOn: 1'b0, crcClear: 1'b0, crcAdd: 1'b0};
    fifoPop  = 1'b0;
    stNext   = st;
    abortGo  = 1'b0;
    if (needByte) begin
      unique case (st)
        ST_IDLE: begin
          if (!pktMode) begin
            if (errLatch) abortGo = 1'b1;
            else if (fifoValid) begin
              strb.src = SRC_DATA;
              fifoPop  = 1'b1;
            end
          end else if (fifoValid) begin
            strb.src      = SRC_FLAG;
            strb.crcClear = 1'b1;
            stNext        = ST_BODY;
          end
        end
        ST_BODY: begin
          if (errLatch || !fifoValid) abortGo = 1'b1;
          else begin
            strb.src     = SRC_DATA;
            strb.stuffOn = 1'b1;
            strb.crcAdd  = 1'b1;
            fifoPop      = 1'b1;
            if (fifoLast) stNext = ST_FCS0;
          end
        end
        ST_FCS0: begin
          if (errLatch) abortGo = 1'b1;
          else begin
            strb.src     = SRC_FCSLO;
            strb.stuffOn = 1'b1;
            stNext       = ST_FCS1;
          end
        end
        ST_FCS1: begin
          if (errLatch) abortGo = 1'b1;
          else begin
            strb.src     = SRC_FCSHI;
            strb.stuffOn = 1'b1;
            stNext       = ST_END;
          end
        end
        ST_END: begin
          if (errLatch) abortGo = 1'b1;
          else begin
            strb.src = SRC_FLAG;
            stNext   = ST_IDLE;
          end
        end
        default: strb.src = SRC_FILL;
      endcase
      if (abortGo) begin
        strb.src = SRC_ABORT;
        stNext   = ST_LOCK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      errLatch <= 1'b0;
      aborted  <= 1'b0;
    end else if (chanReset) begin
      st       <= ST_IDLE;
      errLatch <= 1'b0;
      aborted  <= 1'b0;
    end else begin
      st <= stNext;
      if (upErr && errArm) errLatch <= 1'b1;
      else if (needByte)   errLatch <= 1'b0;
      if (abortGo) aborted <= 1'b1;
    end
  end
endmodule

// File: rtl/hdlcTxDatapath.sv
module hdlcTxDatapath
  import hdlcTxPkg::*;
#(
  parameter logic [FCS_W-1:0]  FCS_POLY  = 16'h8408,
  parameter logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E,
  parameter int                RUN_MAX   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chanReset,
  input  logic              bitEn,
  input  logic              idleFF,
  input  logic [BYTE_W-1:0] fifoData,
  input  txStrobe_t         strb,
  output logic              needByte,
  output logic              txBit
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  logic [BYTE_W-2:0] shReg;
  logic [IDX_W-1:0]  bitIdx;
  logic [RUN_W-1:0]  onesCnt;
  logic              curStuff;
  logic [FCS_W-1:0]  crcReg;
  logic [BYTE_W-1:0] newByte;
  logic              stuffNow, emitBit, bitStuffable, slotStart;

  function automatic logic [FCS_W-1:0] crcNext(input logic [FCS_W-1:0] c,
                                               input logic [BYTE_W-1:0] d);
    logic [FCS_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? FCS_POLY : '0);
    return r;
  endfunction

  assign stuffNow  = (onesCnt == RUN_W'(RUN_MAX));
  assign slotStart = (bitIdx == '0);
  assign needByte  = bitEn && !stuffNow && slotStart;

  always_comb begin
    unique case (strb.src)
      SRC_FLAG:  newByte = FLAG_BYTE;
      SRC_ABORT: newByte = '1;
      SRC_DATA:  newByte = fifoData;
      SRC_FCSLO: newByte = ~crcReg[BYTE_W-1:0];
      SRC_FCSHI: newByte = ~crcReg[FCS_W-1:BYTE_W];
      default:   newByte = idleFF ? '1 : FLAG_BYTE;
    endcase
  end

  assign emitBit      = stuffNow ? 1'b0 : (slotStart ? newByte[0] : shReg[0]);
  assign bitStuffable = slotStart ? strb.stuffOn : curStuff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg    <= '0;
      bitIdx   <= '0;
      onesCnt  <= '0;
      curStuff <= 1'b0;
      crcReg   <= '1;
      txBit    <= 1'b1;
    end else if (chanReset) begin
      shReg    <= '0;
      bitIdx   <= '0;
      onesCnt  <= '0;
      curStuff <= 1'b0;
      crcReg   <= '1;
      txBit    <= 1'b1;
    end else if (bitEn) begin
      txBit <= emitBit;
      if (stuffNow) begin
        onesCnt <= '0;
      end else begin
        if (slotStart) begin
          shReg    <= newByte[BYTE_W-1:1];
          curStuff <= strb.stuffOn;
        end else begin
          shReg <= shReg >> 1;
        end
        bitIdx  <= bitIdx + 1'b1;
        onesCnt <= (bitStuffable && emitBit) ? onesCnt + 1'b1 : '0;
      end
      if (strb.crcClear)    crcReg <= '1;
      else if (strb.crcAdd) crcReg <= crcNext(crcReg, fifoData);
    end
  end
endmodule

// File: rtl/hdlcTx.sv
module hdlcTx
  import hdlcTxPkg::*;
#(
  parameter logic [FCS_W-1:0]  FCS_POLY  = 16'h8408,
  parameter logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chanReset,
  input  logic              bitEn,
  input  logic              pktMode,
  input  logic              idleFF,
  input  logic              upErr,
  input  logic              fifoValid,
  input  logic [BYTE_W-1:0] fifoData,
  input  logic              fifoLast,
  output logic              fifoPop,
  output logic              txBit,
  output logic              aborted
);
  txStrobe_t strb;
  logic      needByte;

  hdlcTxCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .chanReset(chanReset), .pktMode(pktMode),
    .upErr(upErr), .fifoValid(fifoValid), .fifoLast(fifoLast),
    .needByte(needByte), .strb(strb), .fifoPop(fifoPop), .aborted(aborted)
  );

  hdlcTxDatapath #(.FCS_POLY(FCS_POLY), .FLAG_BYTE(FLAG_BYTE)) u_dp (
    .clk(clk), .rst_n(rst_n), .chanReset(chanReset), .bitEn(bitEn),
    .idleFF(idleFF), .fifoData(fifoData), .strb(strb),
    .needByte(needByte), .txBit(txBit)
  );
endmodule

// File: rtl/hdlcTxChecker.sv
module hdlcTxChecker (
  input logic clk,
  input logic rst_n,
  input logic chanReset,
  input logic bitEn,
  input logic fifoValid,
  input logic fifoPop,
  input logic txBit,
  input logic aborted
);
  // R10: lock holds until channel reset
  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (aborted && !chanReset) |=> aborted);

  // R10: locked channel takes nothing from the FIFO
  p_no_pop_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> !fifoPop);

  // R10: channel reset clears the lock
  p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chanReset |=> !aborted);

  // R11: line holds while the bit enable is low
  p_hold_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bitEn && !chanReset) |=> $stable(txBit));

  // R12: pops need a valid head and an enabled bit
  p_pop_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifoPop |-> (fifoValid && bitEn));
endmodule

bind hdlcTx hdlcTxChecker u_chk (
  .clk(clk), .rst_n(rst_n), .chanReset(chanReset), .bitEn(bitEn),
  .fifoValid(fifoValid), .fifoPop(fifoPop), .txBit(txBit), .aborted(aborted)
);

// File: tb/hdlcTx_bench.sv
module hdlcTx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chanReset = 1'b0, bitEn = 1'b0, pktMode = 1'b1, idleFF = 1'b0, upErr = 1'b0;
  logic fifoValid, fifoLast, fifoPop, txBit, aborted;
  logic [7:0] fifoData;

  always #2.5 clk = ~clk;

  hdlcTx u_hdlcTx (
    .clk(clk), .rst_n(rst_n), .chanReset(chanReset), .bitEn(bitEn),
    .pktMode(pktMode), .idleFF(idleFF), .upErr(upErr), .fifoValid(fifoValid),
    .fifoData(fifoData), .fifoLast(fifoLast), .fifoPop(fifoPop),
    .txBit(txBit), .aborted(aborted)
  );

  // FIFO model
  logic [7:0] fmem [128];
  logic       flast [128];
  logic [6:0] rdPtr = '0, wrPtr = '0;
  logic       flushReq = 1'b0;
  assign fifoValid = (rdPtr != wrPtr);
  assign fifoData  = fmem[rdPtr];
  assign fifoLast  = flast[rdPtr];
  always @(posedge clk) begin
    if (flushReq)     rdPtr <= wrPtr;
    else if (fifoPop) rdPtr <= rdPtr + 1'b1;
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  logic got [1024];
  logic exp [1024];
  int gotN = 0, expN = 0, expOnes = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic pushByte(input logic [7:0] b, input logic last);
    fmem[wrPtr] = b;
    flast[wrPtr] = last;
    wrPtr = wrPtr + 1'b1;
  endtask

  task automatic flushFifo();
    @(negedge clk) flushReq = 1'b1;
    @(negedge clk) flushReq = 1'b0;
  endtask

  task automatic doChanReset();
    @(negedge clk);
    bitEn = 1'b0;
    chanReset = 1'b1;
    @(negedge clk) chanReset = 1'b0;
  endtask

  task automatic newSeg();
    gotN = 0;
    expN = 0;
  endtask

  task automatic expByte(input logic [7:0] b, input bit stuffable);
    for (int i = 0; i < 8; i++) begin
      if (expOnes == 5) begin
        exp[expN] = 1'b0; expN++; expOnes = 0;
      end
      exp[expN] = b[i]; expN++;
      expOnes = (stuffable && b[i]) ? expOnes + 1 : 0;
    end
  endtask

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? 16'h8408 : 16'h0000);
    return r;
  endfunction

  task automatic expFrame(input logic [7:0] bb [8], input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    expByte(8'h7E, 0);
    for (int i = 0; i < n; i++) begin
      expByte(bb[i], 1);
      c = crcByte(c, bb[i]);
    end
    expByte(~c[7:0], 1);
    expByte(~c[15:8], 1);
    expByte(8'h7E, 0);
  endtask

  task automatic runBits(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      got[gotN] = txBit;
      gotN++;
    end
  endtask

  task automatic cmpStream(input string req, input string what);
    int bad;
    bad = -1;
    for (int i = 0; i < expN; i++)
      if (bad < 0 && got[i] !== exp[i]) bad = i;
    if (bad < 0) check(1, req, what, 0, 0);
    else check(0, req, {what, " bit"}, int'(got[bad]), int'(exp[bad]));
  endtask

  task automatic testReset();
    check(txBit === 1'b1, "R1", "txBit after reset", int'(txBit), 1);
    check(aborted === 1'b0, "R1", "aborted after reset", int'(aborted), 0);
    check(fifoPop === 1'b0, "R1", "fifoPop after reset", int'(fifoPop), 0);
  endtask

  task automatic testIdle(input logic ff);
    pktMode = 1'b1; idleFF = ff;
    doChanReset();
    newSeg(); expOnes = 0;
    for (int i = 0; i < 3; i++) expByte(ff ? 8'hFF : 8'h7E, 0);
    @(negedge clk) bitEn = 1'b1;
    runBits(expN);
    cmpStream("R2", ff ? "idle FFh" : "idle 7Eh");
  endtask

  task automatic testStuffFrame();
    logic [7:0] bb [8];
    logic hv;
    bit same;
    pktMode = 1'b1; idleFF = 1'b0;
    doChanReset();
    bb[0] = 8'hFF; bb[1] = 8'h3E; bb[2] = 8'hF8;
    pushByte(bb[0], 0); pushByte(bb[1], 0); pushByte(bb[2], 1);
    newSeg(); expOnes = 0;
    expFrame(bb, 3);
    expByte(8'h7E, 0); expByte(8'h7E, 0);
    @(negedge clk) bitEn = 1'b1;
    runBits(20);
    @(negedge clk) bitEn = 1'b0;
    hv = txBit; same = 1;
    repeat (5) begin
      @(negedge clk);
      if (txBit !== hv) same = 0;
    end
    check(same, "R11", "txBit held with bitEn low", int'(txBit), int'(hv));
    bitEn = 1'b1;
    runBits(expN - 20);
    cmpStream("R4", "stuffed frame with CRC (R3)");
    check(!fifoValid, "R12", "all data bytes popped", int'(fifoValid), 0);
  endtask

  task automatic testBackToBack();
    logic [7:0] b1 [8];
    logic [7:0] b2 [8];
    pktMode = 1'b1; idleFF = 1'b1;
    doChanReset();
    b1[0] = 8'h7E; b1[1] = 8'h55; b2[0] = 8'h81;
    pushByte(b1[0], 0); pushByte(b1[1], 1); pushByte(b2[0], 1);
    newSeg(); expOnes = 0;
    expFrame(b1, 2);
    expFrame(b2, 1);
    expByte(8'hFF, 0); expByte(8'hFF, 0);
    @(negedge clk) bitEn = 1'b1;
    runBits(expN);
    cmpStream("R3", "back-to-back frames");
  endtask

  task automatic testUnderflow();
    pktMode = 1'b1; idleFF = 1'b0;
    doChanReset();
    pushByte(8'hA5, 0);
    newSeg(); expOnes = 0;
    expByte(8'h7E, 0); expByte(8'hA5, 1); expByte(8'hFF, 0);
    for (int i = 0; i < 3; i++) expByte(8'h7E, 0);
    @(negedge clk) bitEn = 1'b1;
    runBits(expN);
    cmpStream("R5", "underflow abort");
    @(negedge clk);
    check(aborted === 1'b1, "R5", "aborted after underflow", int'(aborted), 1);
    pushByte(8'h11, 1);
    newSeg();
    for (int i = 0; i < 4; i++) expByte(8'h7E, 0);
    runBits(expN);
    cmpStream("R10", "locked fill with data queued");
    @(negedge clk);
    check(fifoValid === 1'b1, "R10", "queued byte kept while locked", int'(fifoValid), 1);
    check(aborted === 1'b1, "R10", "lock persists", int'(aborted), 1);
    doChanReset();
    check(aborted === 1'b0, "R10", "chanReset clears lock", int'(aborted), 0);
    flushFifo();
  endtask

  task automatic testFrameErr();
    pktMode = 1'b1; idleFF = 1'b0;
    doChanReset();
    for (int i = 0; i < 4; i++) pushByte(8'h00, 0);
    newSeg(); expOnes = 0;
    expByte(8'h7E, 0); expByte(8'h00, 1); expByte(8'hFF, 0);
    expByte(8'h7E, 0); expByte(8'h7E, 0);
    @(negedge clk) bitEn = 1'b1;
    runBits(12);
    @(negedge clk) upErr = 1'b1;
    runBits(1);
    @(negedge clk) upErr = 1'b0;
    runBits(expN - 13);
    cmpStream("R6", "error inside frame aborts");
    check(aborted === 1'b1, "R6", "aborted after frame error", int'(aborted), 1);
    doChanReset();
    flushFifo();
  endtask

  task automatic testIdleErr();
    logic [7:0] bb [8];
    pktMode = 1'b1; idleFF = 1'b1;
    doChanReset();
    newSeg(); expOnes = 0;
    for (int i = 0; i < 4; i++) expByte(8'hFF, 0);
    bb[0] = 8'h00;
    expFrame(bb, 1);
    expByte(8'hFF, 0);
    @(negedge clk) bitEn = 1'b1;
    runBits(8);
    @(negedge clk) upErr = 1'b1;
    runBits(2);
    @(negedge clk) upErr = 1'b0;
    runBits(21);
    check(aborted === 1'b0, "R7", "idle error ignored", int'(aborted), 0);
    @(negedge clk) pushByte(8'h00, 1);
    runBits(expN - 31);
    cmpStream("R7", "frame after idle error");
  endtask

  task automatic testTransparent();
    pktMode = 1'b0; idleFF = 1'b0;
    doChanReset();
    pushByte(8'hFF, 1); pushByte(8'hFF, 0); pushByte(8'h3E, 0);
    newSeg(); expOnes = 0;
    expByte(8'hFF, 0); expByte(8'hFF, 0); expByte(8'h3E, 0);
    expByte(8'h7E, 0); expByte(8'h7E, 0);
    @(negedge clk) bitEn = 1'b1;
    runBits(expN);
    cmpStream("R8", "transparent passthrough and fill");
    check(aborted === 1'b0, "R8", "no abort on empty FIFO", int'(aborted), 0);
  endtask

  task automatic testTransparentErr();
    pktMode = 1'b0; idleFF = 1'b1;
    doChanReset();
    pushByte(8'h11, 0); pushByte(8'h22, 0); pushByte(8'h33, 0);
    newSeg(); expOnes = 0;
    expByte(8'h11, 0); expByte(8'hFF, 0); expByte(8'hFF, 0); expByte(8'hFF, 0);
    @(negedge clk) bitEn = 1'b1;
    runBits(4);
    @(negedge clk) upErr = 1'b1;
    runBits(1);
    @(negedge clk) upErr = 1'b0;
    runBits(expN - 5);
    cmpStream("R9", "transparent error abort");
    @(negedge clk);
    check(aborted === 1'b1, "R9", "aborted in transparent", int'(aborted), 1);
    check(fifoValid === 1'b1, "R12", "only one byte popped", int'(fifoValid), 1);
    doChanReset();
    flushFifo();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testIdle(1'b0);
    testIdle(1'b1);
    testStuffFrame();
    testBackToBack();
    testUnderflow();
    testFrameErr();
    testIdleErr();
    testTransparent();
    testTransparentErr();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule